// File: doc/BRIEF.md
# Linear Array Readout Sequencer

This block is the digital sequencing core of a 128-pixel linear light sensor. It is meant as a synthesizable device model or as a target for test. A one-cycle start strobe is captured on a clock edge. The strobe becomes a single token that walks a 132-stage shift chain. While the token is in the chain, all sample-and-hold capacitors are held apart from their integrators, the integrators are held in reset, and the shared output is driven. The token visits 2 lead dummy stages, then 128 pixel stages, then 2 trail dummy stages. When it falls off the end of the chain, the integrators are released together, integration begins, and the output goes to high impedance. It stays there until the next strobe freezes the samples again.

The analog path is not modelled. A digital test value on `pix_in` stands in for the selected sample and appears on the output data bus during pixel stages. The outgoing data is a stream with a valid flag but no ready input. The sequence is locked to the clock, one stage per cycle, so back-pressure is not possible. A consumer must take every beat in the cycle it is valid. The current position is exported twice, as a one-hot stage vector and as a binary stage index. A strobe that arrives while a token is still moving restarts the walk and sets a sticky overlap flag.

Top module: `srs_readout_seq`

## Requirements
- R1: After reset, `stage_oh` is all zero, `stage_idx` is 0, `out_en`, `out_valid` and `smp_hold` are 0, `out_data` is 0, `overlap` is 0, and `integ_rst` is 1. `integ_rst` stays at 1 through idle cycles until the first strobe is captured.
- R2: A strobe (`si`=1 at a rising edge) places the token on stage 0 in the next cycle. In that cycle `stage_oh` = 1 (bit 0), `stage_idx` = 0, and `integ_rst`, `smp_hold` and `out_en` are all 1.
- R3: With no new strobe, the token moves up by one stage each clock. `stage_idx` counts up by one, and `stage_oh` has exactly the bit `stage_idx` set.
- R4: Stages 0 and 1 (lead) and stages 130 and 131 (trail) are dummies: `out_pix`=0 and `out_data`=0. Stages 2 to 129 select pixel `stage_idx`-2: `pix_sel` has only that bit set, `out_pix`=1, and `out_data` = `pix_in`.
- R5: In the cycle after stage 131, the chain is empty. `integ_rst` and `smp_hold` drop to 0 together, so the integrators were held in reset for exactly 132 cycles.
- R6: Whenever no stage is active, `out_en`, `out_valid` and `out_pix` are 0, `out_data` is 0 and `pix_sel` is 0, until the next strobe. `out_valid` equals `out_en`.
- R7: A strobe captured while a stage is active restarts the token at stage 0 and sets `overlap` to 1. `overlap` then stays at 1 until reset.
- R8: A strobe captured while no stage is active leaves `overlap` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock; one stage per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| si | input | 1 | Start strobe, sampled on the rising edge |
| pix_in | input | DW (8) | Test value standing in for the selected pixel sample |
| stage_oh | output | 132 | One-hot position of the token; zero when idle |
| stage_idx | output | 8 | Binary position of the token; zero when idle |
| pix_sel | output | 128 | One-hot pixel select during pixel stages |
| integ_rst | output | 1 | Integrators held in reset |
| smp_hold | output | 1 | Sample capacitors disconnected from integrators |
| out_en | output | 1 | Output driven; low means high impedance |
| out_valid | output | 1 | Output stream beat valid (no ready; see text) |
| out_pix | output | 1 | Current beat carries a real pixel (not a dummy) |
| out_data | output | DW (8) | Output stream data |
| overlap | output | 1 | Sticky: a strobe arrived during an active walk |

## Verification
The bench drives five kinds of pattern:
- Idle cycles with no strobe. These show that the integrators stay in reset before the first start.
- A full walk with a changing `pix_in` and an idle gap after it. This separates the lead, pixel and trail stages, confirms the release after exactly 132 cycles, and confirms that the output is off in the gap.
- A strobe injected in the middle of a walk. This tells a restart apart from a token that keeps moving, and shows the overlap flag being set.
- A strobe held high over several edges. This shows the token re-seeding stage 0 on each edge.
- A reset asserted in the middle of a walk. This shows that the sticky overlap flag and the token are cleared.

A behavioural reference built from integers is compared with every output on every cycle.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int N_LEAD   = 2;
  localparam int N_PIX    = 128;
  localparam int N_TRAIL  = 2;
  localparam int N_STAGES = N_LEAD + N_PIX + N_TRAIL;
  localparam int IDX_W    = $clog2(N_STAGES);
  localparam int PIX_LO   = N_LEAD;
  localparam int PIX_HI   = N_LEAD + N_PIX - 1;
endpackage

// File: rtl/srs_token_chain.sv
module srs_token_chain #(
  parameter int STAGES = 132
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              si,
  output logic [STAGES-1:0] stage_q
);
  logic [STAGES-1:0] stage_d;

  always_comb begin
    if (si) stage_d = {{(STAGES-1){1'b0}}, 1'b1};
    else    stage_d = {stage_q[STAGES-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/srs_stage_encode.sv
module srs_stage_encode #(
  parameter int STAGES = 132,
  parameter int IDX_W  = 8
) (
  input  logic [STAGES-1:0] stage_oh,
  output logic [IDX_W-1:0]  stage_idx,
  output logic              active
);
  always_comb begin
    stage_idx = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (stage_oh[i]) stage_idx = stage_idx | IDX_W'(i);
    end
  end

  assign active = |stage_oh;
endmodule

// File: rtl/srs_phase_ctrl.sv
module srs_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic si,
  input  logic active,
  output logic integ_rst,
  output logic smp_hold,
  output logic overlap
);
  logic waiting_q;
  logic ovl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b1;
      ovl_q     <= 1'b0;
    end else begin
      if (si) waiting_q <= 1'b0;
      if (si && active) ovl_q <= 1'b1;
    end
  end

  assign integ_rst = waiting_q | active;
  assign smp_hold  = active;
  assign overlap   = ovl_q;
endmodule

// File: rtl/srs_out_mux.sv
module srs_out_mux #(
  parameter int STAGES = 132,
  parameter int N_LEAD = 2,
  parameter int N_PIX  = 128,
  parameter int DW     = 8
) (
  input  logic [STAGES-1:0] stage_oh,
  input  logic              active,
  input  logic [DW-1:0]     pix_in,
  output logic [N_PIX-1:0]  pix_sel,
  output logic              out_en,
  output logic              out_valid,
  output logic              out_pix,
  output logic [DW-1:0]     out_data
);
  assign pix_sel   = stage_oh[N_LEAD +: N_PIX];
  assign out_pix   = |pix_sel;
  assign out_en    = active;
  assign out_valid = active;
  assign out_data  = out_pix ? pix_in : '0;
endmodule

// File: rtl/srs_readout_seq.sv
module srs_readout_seq
  import srs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                si,
  input  logic [DW-1:0]       pix_in,
  output logic [N_STAGES-1:0] stage_oh,
  output logic [IDX_W-1:0]    stage_idx,
  output logic [N_PIX-1:0]    pix_sel,
  output logic                integ_rst,
  output logic                smp_hold,
  output logic                out_en,
  output logic                out_valid,
  output logic                out_pix,
  output logic [DW-1:0]       out_data,
  output logic                overlap
);
  logic active;

  srs_token_chain #(.STAGES(N_STAGES)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .si      (si),
    .stage_q (stage_oh)
  );

  srs_stage_encode #(.STAGES(N_STAGES), .IDX_W(IDX_W)) u_enc (
    .stage_oh  (stage_oh),
    .stage_idx (stage_idx),
    .active    (active)
  );

  srs_phase_ctrl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .si        (si),
    .active    (active),
    .integ_rst (integ_rst),
    .smp_hold  (smp_hold),
    .overlap   (overlap)
  );

  srs_out_mux #(.STAGES(N_STAGES), .N_LEAD(N_LEAD), .N_PIX(N_PIX), .DW(DW)) u_mux (
    .stage_oh  (stage_oh),
    .active    (active),
    .pix_in    (pix_in),
    .pix_sel   (pix_sel),
    .out_en    (out_en),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .out_data  (out_data)
  );
endmodule

// File: rtl/srs_readout_seq_chk.sv
module srs_readout_seq_chk
  import srs_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                si,
  input logic [N_STAGES-1:0] stage_oh,
  input logic [IDX_W-1:0]    stage_idx,
  input logic                integ_rst,
  input logic                smp_hold,
  input logic                out_en,
  input logic                out_valid,
  input logic                out_pix,
  input logic [DW-1:0]       out_data,
  input logic                overlap
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    si |=> (stage_oh[0] && integ_rst && smp_hold && out_en));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage_oh));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!si && out_en && !stage_oh[N_STAGES-1]) |=> (stage_idx == $past(stage_idx) + 1'b1));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!si && stage_oh[N_STAGES-1]) |=> (!integ_rst && !smp_hold && !out_en));

  p_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!out_valid && !out_pix && out_data == '0));

  p_overlap_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (si && out_en) |=> overlap);

  p_overlap_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |=> overlap);

  p_idle_si_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (si && !out_en && !overlap) |=> !overlap);
endmodule

bind srs_readout_seq srs_readout_seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .si        (si),
  .stage_oh  (stage_oh),
  .stage_idx (stage_idx),
  .integ_rst (integ_rst),
  .smp_hold  (smp_hold),
  .out_en    (out_en),
  .out_valid (out_valid),
  .out_pix   (out_pix),
  .out_data  (out_data),
  .overlap   (overlap)
);

// File: tb/tb_srs_readout_seq.sv
`timescale 1ns/1ps
module tb_srs_readout_seq;
  import srs_pkg::*;
  localparam int DW = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                si = 1'b0;
  logic [DW-1:0]       pix_in = '0;
  logic [N_STAGES-1:0] stage_oh;
  logic [IDX_W-1:0]    stage_idx;
  logic [N_PIX-1:0]    pix_sel;
  logic integ_rst, smp_hold, out_en, out_valid, out_pix, overlap;
  logic [DW-1:0]       out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // reference state: position -1 means idle
  int ref_pos = -1;
  int ref_wait = 1;
  int ref_ovl = 0;

  always #2.5 clk = ~clk;

  srs_readout_seq #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .si(si), .pix_in(pix_in),
    .stage_oh(stage_oh), .stage_idx(stage_idx), .pix_sel(pix_sel),
    .integ_rst(integ_rst), .smp_hold(smp_hold), .out_en(out_en),
    .out_valid(out_valid), .out_pix(out_pix), .out_data(out_data),
    .overlap(overlap)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pos = -1; ref_wait = 1; ref_ovl = 0;
    end else if (si) begin
      if (ref_pos >= 0) ref_ovl = 1;
      ref_pos = 0; ref_wait = 0;
    end else if (ref_pos >= 0) begin
      ref_pos = (ref_pos == N_STAGES - 1) ? -1 : ref_pos + 1;
    end
  end

  task automatic chk(input string tag, input logic [N_STAGES-1:0] act,
                     input logic [N_STAGES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d pos=%0d actual=%0h expected=%0h", tag, cyc, ref_pos, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [N_STAGES-1:0] e_oh;
    logic [N_PIX-1:0]    e_sel;
    bit act, pix;
    e_oh = '0; e_sel = '0;
    act = (ref_pos >= 0);
    pix = act && ref_pos >= PIX_LO && ref_pos <= PIX_HI;
    if (act) e_oh[ref_pos] = 1'b1;
    if (pix) e_sel[ref_pos - PIX_LO] = 1'b1;
    chk("R3 stage_oh", stage_oh, e_oh);
    chk("R3 stage_idx", N_STAGES'(stage_idx), act ? N_STAGES'(ref_pos) : '0);
    chk("R1/R5 integ_rst", N_STAGES'(integ_rst), N_STAGES'(act || ref_wait != 0));
    chk("R2/R5 smp_hold", N_STAGES'(smp_hold), N_STAGES'(act));
    chk("R6 out_en", N_STAGES'(out_en), N_STAGES'(act));
    chk("R6 out_valid", N_STAGES'(out_valid), N_STAGES'(act));
    chk("R4 out_pix", N_STAGES'(out_pix), N_STAGES'(pix));
    chk("R4 pix_sel", N_STAGES'(pix_sel), N_STAGES'(e_sel));
    chk("R4 out_data", N_STAGES'(out_data), pix ? N_STAGES'(pix_in) : '0);
    chk("R7/R8 overlap", N_STAGES'(overlap), N_STAGES'(ref_ovl));
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic step(input bit s);
    @(negedge clk);
    cyc++;
    compare_all();
    si = s;
    pix_in = DW'(cyc * 37 + 5);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and idle before the first strobe
    for (int i = 0; i < 6; i++) step(1'b0);
    // R2 R3 R4 R5: full walk, then idle gap (R6)
    step(1'b1);
    for (int i = 0; i < 150; i++) step(1'b0);
    // R8: idle strobe must not set overlap
    step(1'b1);
    for (int i = 0; i < 50; i++) step(1'b0);
    // R7: strobe in mid walk restarts and sets overlap
    step(1'b1);
    for (int i = 0; i < 140; i++) step(1'b0);
    // R7: strobe held high for several edges
    step(1'b1); step(1'b1); step(1'b1);
    for (int i = 0; i < 20; i++) step(1'b0);
    // R1 R7: reset in mid walk clears token and sticky flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 140; i++) step(1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule